// File: doc/BRIEF.md
# Snooping Cache Bus Responder

This block sits beside a write-back cache and watches a shared multiprocessor memory bus. The bus carries commands and data on the same wires. A separate command-cycle strobe marks the cycles that hold a command, and in those cycles the command code occupies the top bits of the data word. On each command cycle the block takes the snooped real address, rejects it outright if the address-extension field is nonzero, and compares the block part of the address against a small register array of resident tags. Each tag entry carries a valid bit and an ownership (master) bit.

The response is registered and appears in the cycle after the command cycle. The hit line reports any tag match. The shared line reports a match on a memory transfer command. The abort line is raised only when a read-quad finds a quadword that this cache owns. The stream-write command is handled exactly like write-quad. Stream-read reports shared but never aborts.

The tag array is loaded one entry per cycle through a fill port. Data supply, the cache data arrays and the processor-side interface are not part of this block.

Top module: `snoop_responder`

## Requirements
- R1: The three response outputs (snoop_hit, snoop_shared, snoop_abort) are high only in the cycle that follows a cycle with bus_cmd_cycle high. Each command cycle yields at most a one-cycle pulse. The command code is bus_data[31:28].
- R2: A match requires a valid entry whose tag equals bus_data[22:2]. The quadword-offset bits bus_data[1:0] play no part in the comparison.
- R3: When the extension field bus_data[27:23] is nonzero, no output is raised, even if the tag bits equal a valid entry.
- R4: snoop_hit is high one cycle after any command cycle that matches, whatever the command code (including idle 0 and I/O codes 5 and 6).
- R5: snoop_shared is high one cycle after a matching command cycle whose code is a memory transfer: read-quad 1, write-quad 2, stream-read 3 or stream-write 4. Codes 0 and 5 through 15 never raise it.
- R6: snoop_abort is high, together with snoop_shared, only for a matching read-quad (code 1) where a matching entry has its master bit set. A hit on a non-owned entry, and a hit by any other command, gives no abort.
- R7: Stream-write (code 4) gives the same response as write-quad (code 2): shared on a hit, never abort.
- R8: With fill_en high at a rising edge, entry fill_idx takes fill_tag, fill_valid and fill_master. A snoop in the same cycle is compared against the entry's previous contents.
- R9: rst_n low clears every valid and master bit and forces all three outputs low at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_cmd_cycle | input | 1 | High in a command cycle |
| bus_data | input | 32 | Bus word: command [31:28], extension [27:23], tag [22:2], offset [1:0] |
| fill_en | input | 1 | Write one tag entry this cycle |
| fill_idx | input | 3 | Entry to write |
| fill_tag | input | 21 | Block tag to store |
| fill_valid | input | 1 | Valid bit to store |
| fill_master | input | 1 | Ownership bit to store |
| snoop_hit | output | 1 | Tag match, one cycle after the command cycle |
| snoop_shared | output | 1 | Shared response line |
| snoop_abort | output | 1 | Abort response line |

## Verification
Every response (hit, shared and abort) is due exactly one clock after the command cycle that causes it. The only exception is reset, which clears the outputs immediately. The bench drives each stimulus on a falling edge and samples the outputs on the next falling edge, so the registered response is read in its one valid cycle. Back-to-back rows check that a response lasts one cycle, and a same-cycle fill-and-snoop check shows that a new entry is seen only one cycle later. For the asynchronous reset check, the bench samples a few nanoseconds after pulling rst_n low in mid-cycle, with no clock edge in between.

// File: rtl/snp_pkg.sv
package snp_pkg;

  localparam int SNP_CMD_W = 4;

  localparam logic [SNP_CMD_W-1:0] CMD_IDLE      = 4'd0;
  localparam logic [SNP_CMD_W-1:0] CMD_RD_QUAD   = 4'd1;
  localparam logic [SNP_CMD_W-1:0] CMD_WR_QUAD   = 4'd2;
  localparam logic [SNP_CMD_W-1:0] CMD_RD_STREAM = 4'd3;
  localparam logic [SNP_CMD_W-1:0] CMD_WR_STREAM = 4'd4;
  localparam logic [SNP_CMD_W-1:0] CMD_IO_RD     = 4'd5;
  localparam logic [SNP_CMD_W-1:0] CMD_IO_WR     = 4'd6;

  // snoop class after decoding; stream write folds into write quad
  typedef enum logic [1:0] {
    CLS_NONE      = 2'd0,
    CLS_RD_QUAD   = 2'd1,
    CLS_WR_QUAD   = 2'd2,
    CLS_RD_STREAM = 2'd3
  } snp_cls_e;

endpackage

// File: rtl/snp_cmd_decode.sv
module snp_cmd_decode
  import snp_pkg::*;
(
  input  logic [SNP_CMD_W-1:0] cmd_code,
  output snp_cls_e             cmd_cls
);

  always_comb begin
    unique case (cmd_code)
      CMD_RD_QUAD:   cmd_cls = CLS_RD_QUAD;
      CMD_WR_QUAD,
      CMD_WR_STREAM: cmd_cls = CLS_WR_QUAD;
      CMD_RD_STREAM: cmd_cls = CLS_RD_STREAM;
      default:       cmd_cls = CLS_NONE;
    endcase
  end

endmodule

// File: rtl/snp_tag_store.sv
module snp_tag_store #(
  parameter int TAG_W   = 21,
  parameter int ENTRIES = 8,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fill_en,
  input  logic [IDX_W-1:0]   fill_idx,
  input  logic [TAG_W-1:0]   fill_tag,
  input  logic               fill_valid,
  input  logic               fill_master,
  output logic [TAG_W-1:0]   tag_q [ENTRIES],
  output logic [ENTRIES-1:0] valid_q,
  output logic [ENTRIES-1:0] master_q
);

  for (genvar i = 0; i < ENTRIES; i++) begin : g_entry
    logic             wr_sel;
    logic             valid_d;
    logic             master_d;
    logic [TAG_W-1:0] tag_d;

    // next-state
    always_comb begin
      wr_sel   = fill_en && (fill_idx == IDX_W'(i));
      valid_d  = wr_sel ? fill_valid  : valid_q[i];
      master_d = wr_sel ? fill_master : master_q[i];
      tag_d    = wr_sel ? fill_tag    : tag_q[i];
    end

    // state bits: reset clears them
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_q[i]  <= 1'b0;
        master_q[i] <= 1'b0;
      end else begin
        valid_q[i]  <= valid_d;
        master_q[i] <= master_d;
      end
    end

    // tag bits: qualified by valid, no reset
    always_ff @(posedge clk) begin
      if (wr_sel) begin
        tag_q[i] <= tag_d;
      end
    end
  end

endmodule

// File: rtl/snp_match.sv
module snp_match #(
  parameter int TAG_W   = 21,
  parameter int EXT_W   = 5,
  parameter int ENTRIES = 8
) (
  input  logic [EXT_W-1:0]   snp_ext,
  input  logic [TAG_W-1:0]   snp_tag,
  input  logic [TAG_W-1:0]   tag_q [ENTRIES],
  input  logic [ENTRIES-1:0] valid_q,
  input  logic [ENTRIES-1:0] master_q,
  output logic               hit_any,
  output logic               owned_any
);

  logic [ENTRIES-1:0] match_vec;
  logic               ext_zero;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign match_vec[i] = valid_q[i] && (tag_q[i] == snp_tag);
  end

  always_comb begin
    ext_zero  = (snp_ext == '0);
    hit_any   = ext_zero && (|match_vec);
    owned_any = ext_zero && (|(match_vec & master_q));
  end

endmodule

// File: rtl/snp_response.sv
module snp_response
  import snp_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     cmd_cycle,
  input  snp_cls_e cmd_cls,
  input  logic     hit_any,
  input  logic     owned_any,
  output logic     hit_q,
  output logic     shared_q,
  output logic     abort_q
);

  logic hit_d;
  logic shared_d;
  logic abort_d;

  always_comb begin
    hit_d    = cmd_cycle && hit_any;
    shared_d = hit_d && (cmd_cls != CLS_NONE);
    abort_d  = shared_d && (cmd_cls == CLS_RD_QUAD) && owned_any;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q    <= 1'b0;
      shared_q <= 1'b0;
      abort_q  <= 1'b0;
    end else begin
      hit_q    <= hit_d;
      shared_q <= shared_d;
      abort_q  <= abort_d;
    end
  end

endmodule

// File: rtl/snoop_responder.sv
module snoop_responder
  import snp_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int EXT_W     = 5,
  parameter int QW_OFF_W  = 2,
  parameter int ENTRIES   = 8,
  localparam int ADDR_W   = DATA_W - SNP_CMD_W,
  localparam int RA_W     = ADDR_W - EXT_W,
  localparam int TAG_W    = RA_W - QW_OFF_W,
  localparam int IDX_W    = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_cmd_cycle,
  input  logic [DATA_W-1:0] bus_data,
  input  logic              fill_en,
  input  logic [IDX_W-1:0]  fill_idx,
  input  logic [TAG_W-1:0]  fill_tag,
  input  logic              fill_valid,
  input  logic              fill_master,
  output logic              snoop_hit,
  output logic              snoop_shared,
  output logic              snoop_abort
);

  logic [SNP_CMD_W-1:0] cmd_code;
  logic [EXT_W-1:0]     snp_ext;
  logic [TAG_W-1:0]     snp_tag;
  logic [QW_OFF_W-1:0]  unused_qw_off;
  snp_cls_e             cmd_cls;
  logic [TAG_W-1:0]     tag_q [ENTRIES];
  logic [ENTRIES-1:0]   valid_q;
  logic [ENTRIES-1:0]   master_q;
  logic                 hit_any;
  logic                 owned_any;

  // field split of the bus word
  assign cmd_code      = bus_data[DATA_W-1 -: SNP_CMD_W];
  assign snp_ext       = bus_data[ADDR_W-1 -: EXT_W];
  assign snp_tag       = bus_data[RA_W-1 : QW_OFF_W];
  assign unused_qw_off = bus_data[QW_OFF_W-1:0];

  snp_cmd_decode u_dec (
    .cmd_code (cmd_code),
    .cmd_cls  (cmd_cls)
  );

  snp_tag_store #(
    .TAG_W   (TAG_W),
    .ENTRIES (ENTRIES)
  ) u_tags (
    .clk         (clk),
    .rst_n       (rst_n),
    .fill_en     (fill_en),
    .fill_idx    (fill_idx),
    .fill_tag    (fill_tag),
    .fill_valid  (fill_valid),
    .fill_master (fill_master),
    .tag_q       (tag_q),
    .valid_q     (valid_q),
    .master_q    (master_q)
  );

  snp_match #(
    .TAG_W   (TAG_W),
    .EXT_W   (EXT_W),
    .ENTRIES (ENTRIES)
  ) u_match (
    .snp_ext   (snp_ext),
    .snp_tag   (snp_tag),
    .tag_q     (tag_q),
    .valid_q   (valid_q),
    .master_q  (master_q),
    .hit_any   (hit_any),
    .owned_any (owned_any)
  );

  snp_response u_resp (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_cycle (bus_cmd_cycle),
    .cmd_cls   (cmd_cls),
    .hit_any   (hit_any),
    .owned_any (owned_any),
    .hit_q     (snoop_hit),
    .shared_q  (snoop_shared),
    .abort_q   (snoop_abort)
  );

endmodule

// File: rtl/snoop_responder_chk.sv
module snoop_responder_chk
  import snp_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int EXT_W  = 5,
  localparam int ADDR_W = DATA_W - SNP_CMD_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_cmd_cycle,
  input logic [DATA_W-1:0] bus_data,
  input logic              snoop_hit,
  input logic              snoop_shared,
  input logic              snoop_abort
);

  logic [SNP_CMD_W-1:0] chk_cmd;
  logic [EXT_W-1:0]     chk_ext;
  logic                 chk_mem_cmd;

  assign chk_cmd     = bus_data[DATA_W-1 -: SNP_CMD_W];
  assign chk_ext     = bus_data[ADDR_W-1 -: EXT_W];
  assign chk_mem_cmd = (chk_cmd >= CMD_RD_QUAD) && (chk_cmd <= CMD_WR_STREAM);

  // R1
  no_resp_after_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_cmd_cycle |=> !snoop_hit && !snoop_shared && !snoop_abort);

  // R3
  ext_blocks_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cmd_cycle && (chk_ext != '0)) |=> !snoop_hit && !snoop_shared);

  // R5
  shared_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snoop_shared |-> snoop_hit);

  // R5
  non_mem_no_shared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cmd_cycle && !chk_mem_cmd) |=> !snoop_shared);

  // R6
  abort_only_rdquad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cmd_cycle && (chk_cmd != CMD_RD_QUAD)) |=> !snoop_abort);

  // R6
  abort_with_shared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snoop_abort |-> snoop_shared);

  // R9
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> !snoop_hit && !snoop_shared && !snoop_abort);

endmodule

bind snoop_responder snoop_responder_chk #(
  .DATA_W (DATA_W),
  .EXT_W  (EXT_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .bus_cmd_cycle (bus_cmd_cycle),
  .bus_data      (bus_data),
  .snoop_hit     (snoop_hit),
  .snoop_shared  (snoop_shared),
  .snoop_abort   (snoop_abort)
);

// File: tb/snoop_responder_tb.sv
module snoop_responder_tb;

  logic        clk;
  logic        rst_n;
  logic        bus_cmd_cycle;
  logic [31:0] bus_data;
  logic        fill_en;
  logic [2:0]  fill_idx;
  logic [20:0] fill_tag;
  logic        fill_valid;
  logic        fill_master;
  logic        snoop_hit;
  logic        snoop_shared;
  logic        snoop_abort;

  int n_cmp;
  int n_bad;

  snoop_responder u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_cmd_cycle (bus_cmd_cycle),
    .bus_data      (bus_data),
    .fill_en       (fill_en),
    .fill_idx      (fill_idx),
    .fill_tag      (fill_tag),
    .fill_valid    (fill_valid),
    .fill_master   (fill_master),
    .snoop_hit     (snoop_hit),
    .snoop_shared  (snoop_shared),
    .snoop_abort   (snoop_abort)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  localparam logic [20:0] T0 = 21'h00123;  // entry 0, owned
  localparam logic [20:0] T1 = 21'h0ABCD;  // entry 1, not owned
  localparam logic [20:0] T2 = 21'h1F00F;  // entry 2, invalid
  localparam logic [20:0] T3 = 21'h00555;  // not loaded at first

  typedef struct packed {
    logic        cc;
    logic [3:0]  cmd;
    logic [4:0]  ext;
    logic [20:0] tag;
    logic [1:0]  off;
    logic [2:0]  exp;   // {hit, shared, abort}
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 4'd1, 5'd0,  T0, 2'd0, 3'b111, 4'd6},  // R6 owned read-quad aborts
    '{1'b0, 4'd1, 5'd0,  T0, 2'd0, 3'b000, 4'd1},  // R1 data cycle, pulse ends
    '{1'b1, 4'd1, 5'd0,  T0, 2'd3, 3'b111, 4'd2},  // R2 offset ignored
    '{1'b1, 4'd1, 5'd0,  T1, 2'd1, 3'b110, 4'd6},  // R6 not owned, no abort
    '{1'b1, 4'd2, 5'd0,  T0, 2'd0, 3'b110, 4'd5},  // R5 write-quad hit
    '{1'b1, 4'd4, 5'd0,  T0, 2'd2, 3'b110, 4'd7},  // R7 stream-write like write-quad
    '{1'b1, 4'd4, 5'd0,  T1, 2'd0, 3'b110, 4'd7},  // R7 stream-write on non-owned
    '{1'b1, 4'd3, 5'd0,  T0, 2'd0, 3'b110, 4'd6},  // R6 stream-read never aborts
    '{1'b1, 4'd1, 5'd0,  T2, 2'd0, 3'b000, 4'd2},  // R2 invalid entry
    '{1'b1, 4'd1, 5'd0,  T3, 2'd0, 3'b000, 4'd2},  // R2 miss
    '{1'b1, 4'd1, 5'd1,  T0, 2'd0, 3'b000, 4'd3},  // R3 extension lsb set
    '{1'b1, 4'd1, 5'h10, T0, 2'd0, 3'b000, 4'd3},  // R3 extension msb set
    '{1'b1, 4'd5, 5'd0,  T0, 2'd0, 3'b100, 4'd4},  // R4 I/O read hit, no shared
    '{1'b1, 4'd0, 5'd0,  T1, 2'd0, 3'b100, 4'd4},  // R4 idle code hit
    '{1'b1, 4'd9, 5'd0,  T0, 2'd0, 3'b100, 4'd5},  // R5 unused code not shared
    '{1'b1, 4'd2, 5'd0,  T1, 2'd0, 3'b110, 4'd5}   // R5 write-quad on non-owned
  };

  function automatic logic [2:0] outs();
    return {snoop_hit, snoop_shared, snoop_abort};
  endfunction

  task automatic check(input string tag, input logic [2:0] got, input logic [2:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got hit/shared/abort=%b expected %b", tag, got, exp);
    end
  endtask

  task automatic drive_cmd(input logic cc, input logic [3:0] cmd, input logic [4:0] ext,
                           input logic [20:0] tag, input logic [1:0] off);
    bus_cmd_cycle = cc;
    bus_data      = {cmd, ext, tag, off};
  endtask

  task automatic load(input logic [2:0] idx, input logic [20:0] tag,
                      input logic v, input logic m);
    fill_en     = 1'b1;
    fill_idx    = idx;
    fill_tag    = tag;
    fill_valid  = v;
    fill_master = m;
    @(negedge clk);
    fill_en     = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin : main
    n_cmp = 0;
    n_bad = 0;
    rst_n = 1'b0;
    fill_en = 1'b0;
    fill_idx = '0;
    fill_tag = '0;
    fill_valid = 1'b0;
    fill_master = 1'b0;
    drive_cmd(1'b0, 4'd0, 5'd0, '0, 2'd0);
    repeat (3) @(negedge clk);
    check("R9 outputs low in reset", outs(), 3'b000);
    rst_n = 1'b1;

    // R9: nothing valid after reset
    drive_cmd(1'b1, 4'd1, 5'd0, T0, 2'd0);
    @(negedge clk);
    check("R9 no entry valid after reset", outs(), 3'b000);
    drive_cmd(1'b0, 4'd0, 5'd0, '0, 2'd0);

    load(3'd0, T0, 1'b1, 1'b1);
    load(3'd1, T1, 1'b1, 1'b0);
    load(3'd2, T2, 1'b0, 1'b1);

    // table walk: drive at a falling edge, check at the next one
    for (int i = 0; i < NV; i++) begin
      drive_cmd(VEC[i].cc, VEC[i].cmd, VEC[i].ext, VEC[i].tag, VEC[i].off);
      @(negedge clk);
      check($sformatf("R%0d vector %0d", VEC[i].req, i), outs(), VEC[i].exp);
    end
    drive_cmd(1'b0, 4'd0, 5'd0, '0, 2'd0);
    @(negedge clk);
    check("R1 idle after table", outs(), 3'b000);

    // R8: fill and snoop in the same cycle sees old contents
    fill_en = 1'b1; fill_idx = 3'd3; fill_tag = T3; fill_valid = 1'b1; fill_master = 1'b1;
    drive_cmd(1'b1, 4'd1, 5'd0, T3, 2'd0);
    @(negedge clk);
    check("R8 same-cycle fill not yet visible", outs(), 3'b000);
    fill_en = 1'b0;
    @(negedge clk);
    check("R8 filled entry hits next cycle", outs(), 3'b111);

    // R8/R6: rewriting entry 0 without ownership removes the abort
    drive_cmd(1'b0, 4'd0, 5'd0, '0, 2'd0);
    load(3'd0, T0, 1'b1, 1'b0);
    drive_cmd(1'b1, 4'd1, 5'd0, T0, 2'd0);
    @(negedge clk);
    check("R6 refilled non-owned entry no abort", outs(), 3'b110);

    // R8: invalidate entry 1 through the fill port
    drive_cmd(1'b0, 4'd0, 5'd0, '0, 2'd0);
    load(3'd1, T1, 1'b0, 1'b0);
    drive_cmd(1'b1, 4'd2, 5'd0, T1, 2'd0);
    @(negedge clk);
    check("R8 invalidated entry misses", outs(), 3'b000);

    // R9: asynchronous reset mid-cycle
    drive_cmd(1'b1, 4'd1, 5'd0, T3, 2'd0);
    @(posedge clk);
    #2;
    check("R9 response present before reset", outs(), 3'b111);
    rst_n = 1'b0;
    #1;
    check("R9 async clear without clock", outs(), 3'b000);
    @(negedge clk);
    rst_n = 1'b1;
    drive_cmd(1'b1, 4'd1, 5'd0, T3, 2'd0);
    @(negedge clk);
    check("R9 valid bits cleared by reset", outs(), 3'b000);
    drive_cmd(1'b0, 4'd0, 5'd0, '0, 2'd0);
    @(negedge clk);

    summary();
  end

endmodule